// File: doc/BRIEF.md
# Four-Channel Shadowed PWM Generator

This block drives four pulse-width modulated outputs, one per channel, from a single clock. Software programs each channel through a small register bus. Each channel has a prescaler that slows the clock into counting steps and a step counter that wraps after a programmable modulus. The output is high while the step count is below the duty value. One period therefore lasts (prescale+1)·modulus clock cycles, and the high part lasts (prescale+1)·duty cycles.

Prescale and modulus writes only update pending copies. A write to the duty register captures pending prescale, pending modulus and the new duty as one staged set. The staged set replaces the active set at the next period boundary, so a period never mixes old and new settings. Clearing the enable bit stops the channel in the next cycle, whatever the phase of the period.

Each channel runs a two-state machine. In `CH_OFF` the output is low, both counters are zero and any staged set is loaded at once. In `CH_RUN` the counters advance. The transition *start* (enable written with 1 in `CH_OFF`) enters `CH_RUN` with both counters at zero. The transition *halt* (enable written with 0 in `CH_RUN`) returns to `CH_OFF`. Every other enable write leaves the state as it is.

Top module: `pwm_quad_ctrl`

## Requirements
- R1: Byte address bits [6:5] select the channel and bits [4:0] the register. Offset 0x00 is prescale (8 bits), 0x04 is modulus (8 bits), 0x08 is duty (16 bits) and 0x18 is enable (bit 0). Prescale, modulus and duty read back the last written value truncated to the field width. Enable reads back the running bit. Every other offset reads as zero.
- R2: When a channel is running with prescale P, modulus M≥1 and duty D, the output n cycles after the start edge equals (floor(n/(P+1)) mod M) < D. The first period therefore begins high on the cycle right after the enable write.
- R3: A duty of zero keeps the output low. A duty greater than or equal to the modulus keeps it high. A modulus of zero keeps it low.
- R4: While a channel runs, a write to prescale or modulus without a following duty write does not change the output.
- R5: A duty write stages the pending prescale, the pending modulus and the new duty. The staged set becomes active on the clock edge that ends the current period. A duty write that lands on a boundary edge waits for the following boundary.
- R6: A second duty write before the boundary replaces the earlier staged set.
- R7: Writing 0 to enable drives the output low on the next cycle and enable reads back 0. Enabling again restarts the period at count zero with the most recently staged set, including a set staged while halted or on the halt edge.
- R8: The channels count and commit independently. A write to one channel does not alter another channel's output or registers.
- R9: After reset all registers read as zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the counting source |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one register write per cycle |
| bus_addr | input | 7 | Byte address: channel in [6:5], offset in [4:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_o | output | 4 | One PWM output per channel |

## Verification
A commit and a period boundary can land in the same cycle, and so can a halt and a boundary with a staged set waiting. The bench places a duty write exactly on the edge that ends a four-step period. It then checks that the next period still shows the old duty and that only the period after it shows the new duty. It also issues a halt on a boundary edge while a set is staged, and checks that the output drops at once and that the following start runs with the staged duty.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

    parameter int PRE_W  = 8;
    parameter int MOD_W  = 8;
    parameter int DUTY_W = 16;
    parameter int REG_W  = 32;
    parameter int OFS_W  = 5;

    localparam logic [OFS_W-1:0] OFS_PRE  = 5'h00;
    localparam logic [OFS_W-1:0] OFS_MOD  = 5'h04;
    localparam logic [OFS_W-1:0] OFS_DUTY = 5'h08;
    localparam logic [OFS_W-1:0] OFS_EN   = 5'h18;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [MOD_W-1:0]  mdl;
        logic [DUTY_W-1:0] duty;
    } pwm_set_t;

    typedef enum logic {
        CH_OFF = 1'b0,
        CH_RUN = 1'b1
    } ch_state_t;

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
    import pwm_quad_pkg::*;
#(
    parameter int CH_IDX   = 0,
    parameter int CH_SEL_W = 2,
    localparam int ADDR_W  = CH_SEL_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              run_i,
    input  logic              take_i,
    output pwm_set_t          stg_o,
    output logic              stg_vld_o,
    output logic              en_wr_o,
    output logic              en_val_o,
    output logic [REG_W-1:0]  rdata_o
);

    logic [PRE_W-1:0]  pend_pre;
    logic [MOD_W-1:0]  pend_mdl;
    logic [DUTY_W-1:0] pend_duty;
    logic [OFS_W-1:0]  ofs;
    logic              hit;
    logic              wr_pre, wr_mdl, wr_duty;
    logic              wdata_unused;

    assign ofs          = bus_addr[OFS_W-1:0];
    assign hit          = bus_wr && (bus_addr[ADDR_W-1:OFS_W] == CH_SEL_W'(CH_IDX));
    assign wr_pre       = hit && (ofs == OFS_PRE);
    assign wr_mdl       = hit && (ofs == OFS_MOD);
    assign wr_duty      = hit && (ofs == OFS_DUTY);
    assign en_wr_o      = hit && (ofs == OFS_EN);
    assign en_val_o     = bus_wdata[0];
    assign wdata_unused = ^bus_wdata[REG_W-1:DUTY_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_pre  <= '0;
            pend_mdl  <= '0;
            pend_duty <= '0;
        end else begin
            if (wr_pre)  pend_pre  <= bus_wdata[PRE_W-1:0];
            if (wr_mdl)  pend_mdl  <= bus_wdata[MOD_W-1:0];
            if (wr_duty) pend_duty <= bus_wdata[DUTY_W-1:0];
        end
    end

    // Staging: a newer duty write wins over the release of an older set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_o     <= '0;
            stg_vld_o <= 1'b0;
        end else if (wr_duty) begin
            stg_o     <= '{pre: pend_pre, mdl: pend_mdl, duty: bus_wdata[DUTY_W-1:0]};
            stg_vld_o <= 1'b1;
        end else if (take_i) begin
            stg_vld_o <= 1'b0;
        end
    end

    always_comb begin
        unique case (ofs)
            OFS_PRE:  rdata_o = REG_W'(pend_pre);
            OFS_MOD:  rdata_o = REG_W'(pend_mdl);
            OFS_DUTY: rdata_o = REG_W'(pend_duty);
            OFS_EN:   rdata_o = REG_W'(run_i);
            default:  rdata_o = '0;
        endcase
    end

    // R5
    duty_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_duty |=> (stg_vld_o && stg_o.duty == $past(bus_wdata[DUTY_W-1:0])));

    // R6
    stage_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_vld_o && !wr_duty && !take_i) |=> (stg_vld_o && $stable(stg_o)));

endmodule

// File: rtl/pwm_chan_engine.sv
module pwm_chan_engine
    import pwm_quad_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_wr_i,
    input  logic     en_val_i,
    input  pwm_set_t stg_i,
    input  logic     stg_vld_i,
    output logic     take_o,
    output logic     run_o,
    output logic     pwm_o
);

    ch_state_t        state, state_nx;
    pwm_set_t         act;
    logic [PRE_W-1:0] pcnt;
    logic [MOD_W-1:0] scnt;
    logic [MOD_W:0]   scnt_inc;
    logic             last_step;
    logic             step_tick;
    logic             period_end;

    assign scnt_inc   = {1'b0, scnt} + 1'b1;
    assign last_step  = (scnt_inc >= {1'b0, act.mdl});
    assign step_tick  = (pcnt == act.pre);
    assign period_end = (state == CH_RUN) && step_tick && last_step;
    assign take_o     = stg_vld_i && ((state == CH_OFF) || period_end);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_OFF;
        else        state <= state_nx;
    end

    // Transitions: start and halt
    always_comb begin
        state_nx = state;
        unique case (state)
            CH_OFF: if (en_wr_i &&  en_val_i) state_nx = CH_RUN;
            CH_RUN: if (en_wr_i && !en_val_i) state_nx = CH_OFF;
            default: state_nx = CH_OFF;
        endcase
    end

    // Prescale and step counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
            scnt <= '0;
        end else if (state != CH_RUN || state_nx != CH_RUN) begin
            pcnt <= '0;
            scnt <= '0;
        end else if (step_tick) begin
            pcnt <= '0;
            scnt <= last_step ? '0 : scnt_inc[MOD_W-1:0];
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    // Active set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      act <= '0;
        else if (take_o) act <= stg_i;
    end

    // Outputs
    always_comb begin
        run_o = (state == CH_RUN);
        pwm_o = (state == CH_RUN) && (act.mdl != '0) &&
                ({{(DUTY_W-MOD_W){1'b0}}, scnt} < act.duty);
    end

    // R7
    halt_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr_i && !en_val_i) |=> (!pwm_o && !run_o));

    // R5
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RUN && !period_end) |=> $stable(act));

    // R7
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_OFF) |-> (pcnt == '0 && scnt == '0));

    // R2
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RUN && act.mdl != '0) |-> (scnt < act.mdl && pcnt <= act.pre));

endmodule

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl
    import pwm_quad_pkg::*;
#(
    parameter int  NCH      = 4,
    localparam int CH_SEL_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int ADDR_W   = CH_SEL_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    pwm_o
);

    logic [REG_W-1:0] ch_rdata [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_set_t stg;
        logic     stg_vld, take, run, en_wr, en_val;

        pwm_chan_regs #(
            .CH_IDX   (c),
            .CH_SEL_W (CH_SEL_W)
        ) regs_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_wr    (bus_wr),
            .bus_addr  (bus_addr),
            .bus_wdata (bus_wdata),
            .run_i     (run),
            .take_i    (take),
            .stg_o     (stg),
            .stg_vld_o (stg_vld),
            .en_wr_o   (en_wr),
            .en_val_o  (en_val),
            .rdata_o   (ch_rdata[c])
        );

        pwm_chan_engine eng_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_wr_i   (en_wr),
            .en_val_i  (en_val),
            .stg_i     (stg),
            .stg_vld_i (stg_vld),
            .take_o    (take),
            .run_o     (run),
            .pwm_o     (pwm_o[c])
        );
    end

    assign bus_rdata = ch_rdata[bus_addr[ADDR_W-1:OFS_W]];

    // R8
    one_hot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({g_ch[3].en_wr, g_ch[2].en_wr, g_ch[1].en_wr, g_ch[0].en_wr}));

endmodule

// File: tb/pwm_quad_ctrl_tb_top.sv
module pwm_quad_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_PRE = 5'h00, A_MOD = 5'h04, A_DUTY = 5'h08, A_EN = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_o;

    int n = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pwm_quad_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic exp_out(int pre, int mdl, int duty, int k);
        if (mdl == 0) return 1'b0;
        return ((k / (pre + 1)) % mdl) < duty;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1; n++;
    endtask

    task automatic wr(int ch, logic [4:0] ofs, logic [31:0] v);
        bus_wr = 1'b1; bus_addr = {ch[1:0], ofs}; bus_wdata = v;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(int ch, logic [4:0] ofs, output logic [31:0] v);
        bus_addr = {ch[1:0], ofs}; #1; v = bus_rdata;
    endtask

    task automatic wait_to(int target);
        while (n < target) tick();
    endtask

    task automatic cfg(int ch, int pre, int mdl, int duty);
        wr(ch, A_EN, 0); wr(ch, A_PRE, pre); wr(ch, A_MOD, mdl); wr(ch, A_DUTY, duty);
    endtask

    task automatic start(int ch);
        wr(ch, A_EN, 1); n = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R9: reset state
        chk("R9", "outputs after reset", {28'b0, pwm_o}, 32'h0);
        for (int c = 0; c < 4; c++) begin
            rd(c, A_PRE, v);  chk("R9", "prescale reset", v, 0);
            rd(c, A_MOD, v);  chk("R9", "modulus reset", v, 0);
            rd(c, A_DUTY, v); chk("R9", "duty reset", v, 0);
            rd(c, A_EN, v);   chk("R9", "enable reset", v, 0);
        end
        tick();

        // R1: field widths, read-back, unmapped offsets
        wr(3, A_PRE, 32'h1A5); wr(3, A_MOD, 32'h37C); wr(3, A_DUTY, 32'h12345);
        wr(2, A_PRE, 32'h11);
        rd(3, A_PRE, v);  chk("R1", "prescale readback", v, 32'hA5);
        rd(3, A_MOD, v);  chk("R1", "modulus readback", v, 32'h7C);
        rd(3, A_DUTY, v); chk("R1", "duty readback", v, 32'h2345);
        rd(3, 5'h0C, v);  chk("R1", "unmapped 0x0C", v, 0);
        tick();
        wr(3, A_EN, 32'h3);
        rd(3, A_EN, v);   chk("R1", "enable readback", v, 1);
        rd(3, 5'h14, v);  chk("R1", "unmapped 0x14", v, 0);
        // R8: channel 2 untouched by channel 3 traffic
        rd(2, A_PRE, v);  chk("R8", "neighbour prescale", v, 32'h11);
        rd(2, A_MOD, v);  chk("R8", "neighbour modulus", v, 0);
        tick();
        wr(3, A_EN, 0);

        // R2 R3: sweep prescale, modulus and duty, rotating channels
        begin
            int idx = 0;
            for (int pre = 0; pre < 3; pre++)
                for (int mdl = 0; mdl < 6; mdl++)
                    for (int duty = 0; duty < 7; duty++) begin
                        int ch = idx % 4;
                        int per = (pre + 1) * ((mdl == 0) ? 1 : mdl);
                        int bad = -1;
                        logic got = 1'b0, want = 1'b0;
                        idx++;
                        cfg(ch, pre, mdl, duty);
                        start(ch);
                        for (int k = 0; k < 2 * per; k++) begin
                            if (bad < 0 && pwm_o[ch] !== exp_out(pre, mdl, duty, k)) begin
                                bad = k; got = pwm_o[ch]; want = exp_out(pre, mdl, duty, k);
                            end
                            tick();
                        end
                        if (bad >= 0)
                            $display("  mismatch ch%0d pre=%0d mod=%0d duty=%0d at cycle %0d",
                                     ch, pre, mdl, duty, bad);
                        chk((duty == 0 || duty >= mdl || mdl == 0) ? "R3" : "R2",
                            "sweep waveform", {31'b0, got}, {31'b0, want});
                        wr(ch, A_EN, 0);
                    end
        end

        // R4: modulus and prescale writes alone leave the running output alone
        cfg(1, 0, 4, 1);
        start(1);
        chk("R2", "high at start", pwm_o[1], 1);
        wait_to(1); wr(1, A_MOD, 8);
        chk("R4", "n2 after modulus write", pwm_o[1], 0);
        wait_to(4);
        chk("R4", "n4 old period restart", pwm_o[1], 1);
        wait_to(5); wr(1, A_PRE, 3);
        wait_to(8);
        chk("R4", "n8 prescale write ignored", pwm_o[1], 1);
        // R5: duty write commits at the boundary only
        wr(1, A_DUTY, 3);
        chk("R5", "n9 old duty kept", pwm_o[1], 0);
        wait_to(11); chk("R5", "n11 old duty kept", pwm_o[1], 0);
        wait_to(12); chk("R5", "n12 new set active", pwm_o[1], 1);
        wait_to(23); chk("R5", "n23 new high end", pwm_o[1], 1);
        wait_to(24); chk("R5", "n24 new low", pwm_o[1], 0);
        wait_to(43); chk("R5", "n43 end of long period", pwm_o[1], 0);
        wait_to(44); chk("R5", "n44 next period", pwm_o[1], 1);

        // R6: the newer staged set wins
        cfg(1, 0, 6, 1);
        start(1);
        wait_to(1); wr(1, A_DUTY, 2); wr(1, A_DUTY, 5);
        wait_to(4);  chk("R6", "n4 old duty", pwm_o[1], 0);
        wait_to(8);  chk("R6", "n8 newest duty", pwm_o[1], 1);
        wait_to(10); chk("R6", "n10 newest duty", pwm_o[1], 1);
        wait_to(11); chk("R6", "n11 low", pwm_o[1], 0);

        // R5: duty write on the boundary edge waits a full period
        cfg(1, 0, 4, 1);
        start(1);
        wait_to(3); wr(1, A_DUTY, 3);
        wait_to(4);  chk("R5", "collision n4", pwm_o[1], 1);
        wait_to(5);  chk("R5", "collision n5 old", pwm_o[1], 0);
        wait_to(10); chk("R5", "collision n10 new", pwm_o[1], 1);
        wait_to(11); chk("R5", "collision n11", pwm_o[1], 0);
        // R7: halt on a boundary edge with a set staged
        wait_to(13); wr(1, A_DUTY, 0);
        wait_to(15); wr(1, A_EN, 0);
        chk("R7", "halt on boundary", pwm_o[1], 0);
        rd(1, A_EN, v); chk("R7", "enable reads 0", v, 0);
        tick();
        start(1);
        chk("R7", "restart uses staged duty 0", pwm_o[1], 0);
        wait_to(2); chk("R7", "restart stays low", pwm_o[1], 0);

        // R7 R3: immediate halt mid-period, constant high with duty >= modulus
        cfg(1, 0, 8, 8);
        start(1);
        wait_to(5); chk("R3", "duty equals modulus high", pwm_o[1], 1);
        wr(1, A_EN, 0);
        chk("R7", "halt mid-period", pwm_o[1], 0);
        tick(); chk("R7", "stays low", pwm_o[1], 0);
        start(1);
        chk("R7", "restart high", pwm_o[1], 1);
        wr(1, A_EN, 0);

        // R8: two channels running side by side
        cfg(0, 1, 3, 1);
        cfg(2, 0, 5, 4);
        start(0);
        wr(2, A_EN, 1);
        begin
            int bad0 = 0, bad2 = 0;
            for (int k = 1; k < 31; k++) begin
                if (pwm_o[0] !== exp_out(1, 3, 1, k)) bad0++;
                if (pwm_o[2] !== exp_out(0, 5, 4, k - 1)) bad2++;
                if (k == 10) wr(2, A_MOD, 2); else tick();
            end
            chk("R8", "channel 0 waveform mismatches", bad0, 0);
            chk("R8", "channel 2 waveform mismatches", bad2, 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule